// File: doc/BRIEF.md
# Interrupt State Enable Test Bank

This block holds the interrupt bookkeeping for a peripheral with up to one register width of interrupt sources. There are three word registers at consecutive word offsets: a sticky state register, an enable register and a test register. The state register latches rising edges seen on the per-source event inputs and keeps them until software writes ones to clear them. The enable register chooses which latched sources drive their interrupt output. The test register is write-only and is not stored. A write to it acts for one cycle and sets the matching state bits, so software can raise any interrupt on purpose.

Software reaches the bank over a simple register port. The port has a byte address, a write strobe, write data and read data that follows the address combinationally. Each interrupt output is the registered AND of its state bit and its enable bit. Source `i` always sits at bit `i` of every register.

Top module: `irq_bank`

## Requirements
- R1: After reset the state register, the enable register and every interrupt output are 0.
- R2: Byte address 0 selects state, address W selects enable and address 2W selects test, where W is the register width in bytes (4 at a width of 32). A read of state or enable returns the register in bits NUM_SRC-1:0 and zero in every bit above.
- R3: A write to the enable offset stores write-data bits NUM_SRC-1:0. Reading enable back returns those bits.
- R4: A 0-to-1 transition on event input i sets state bit i on the next clock edge. An input held high does not set the bit again after software has cleared it.
- R5: A write to the state offset clears each state bit whose write-data bit is 1. State bits whose write-data bit is 0 keep their value.
- R6: When a set (from an event edge) and a software clear reach the same state bit in the same cycle, the bit ends up set.
- R7: A write to the test offset sets each state bit whose write-data bit is 1, for that one write only. The test value is not kept, and a read of the test offset returns 0.
- R8: Interrupt output i equals state bit i AND enable bit i, taken from the values in the previous cycle (one register stage).
- R9: A read of any other offset returns 0. A write to any other offset changes neither state nor enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| reg_addr_i | input | AW | Byte address of the register access |
| reg_we_i | input | 1 | Write strobe, one write per cycle it is high |
| reg_wdata_i | input | DW | Write data |
| reg_rdata_o | output | DW | Read data for the current address |
| event_i | input | NUM_SRC | Per-source event inputs, edge-detected |
| irq_o | output | NUM_SRC | Per-source interrupt outputs |

## Verification
Directed stimulus covers these cases:
- a single event edge with the source then held high, which separates edge detection from level detection;
- clears that hit some bits and miss others;
- a clear that collides with a fresh edge on the same bit;
- test writes that include bits above the source count, followed by a clear that shows the test value is not stored;
- enable patterns that mask part of the pending state.

A pseudo-random phase then mixes event toggles with writes and reads to all three offsets and to an unmapped offset. A behavioural model is compared every cycle, so a wrong priority between set and clear, or a missing output register stage, appears as a mismatch.

// File: rtl/irq_bank.sv
module irq_bank #(
  parameter int NUM_SRC = 32,
  parameter int DW      = 32,
  parameter int AW      = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [AW-1:0]      reg_addr_i,
  input  logic               reg_we_i,
  input  logic [DW-1:0]      reg_wdata_i,
  output logic [DW-1:0]      reg_rdata_o,
  input  logic [NUM_SRC-1:0] event_i,
  output logic [NUM_SRC-1:0] irq_o
);
  localparam int WORD_BYTES = DW / 8;
  localparam logic [AW-1:0] OFF_STATE = '0;
  localparam logic [AW-1:0] OFF_EN    = AW'(WORD_BYTES);
  localparam logic [AW-1:0] OFF_TEST  = AW'(2 * WORD_BYTES);

  logic [NUM_SRC-1:0] state_q, en_q, evt_q, irq_q;
  logic [NUM_SRC-1:0] wmask, test_set, hw_set, sw_clr;
  logic hit_state, hit_en, hit_test;

  assign hit_state = reg_addr_i == OFF_STATE;
  assign hit_en    = reg_addr_i == OFF_EN;
  assign hit_test  = reg_addr_i == OFF_TEST;

  assign wmask    = reg_wdata_i[NUM_SRC-1:0];
  assign test_set = (reg_we_i && hit_test) ? wmask : '0;
  assign hw_set   = (event_i & ~evt_q) | test_set;
  assign sw_clr   = (reg_we_i && hit_state) ? wmask : '0;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      evt_q   <= '0;
      state_q <= '0;
      en_q    <= '0;
      irq_q   <= '0;
    end else begin
      evt_q   <= event_i;
      state_q <= (state_q & ~sw_clr) | hw_set;
      if (reg_we_i && hit_en) en_q <= wmask;
      irq_q   <= state_q & en_q;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (hit_state)   reg_rdata_o = DW'(state_q);
    else if (hit_en) reg_rdata_o = DW'(en_q);
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/irq_bank_chk.sv
module irq_bank_chk #(
  parameter int NUM_SRC = 32,
  parameter int DW      = 32,
  parameter int AW      = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [AW-1:0]      reg_addr_i,
  input logic               reg_we_i,
  input logic [DW-1:0]      reg_wdata_i,
  input logic [DW-1:0]      reg_rdata_o,
  input logic [NUM_SRC-1:0] event_i,
  input logic [NUM_SRC-1:0] irq_o,
  input logic [NUM_SRC-1:0] state_q,
  input logic [NUM_SRC-1:0] en_q,
  input logic [NUM_SRC-1:0] evt_q
);
  localparam logic [AW-1:0] C_STATE = '0;
  localparam logic [AW-1:0] C_EN    = AW'(DW / 8);
  localparam logic [AW-1:0] C_TEST  = AW'(2 * (DW / 8));

  logic wr_state, wr_test, wr_other;
  assign wr_state = reg_we_i && reg_addr_i == C_STATE;
  assign wr_test  = reg_we_i && reg_addr_i == C_TEST;
  assign wr_other = reg_we_i && reg_addr_i != C_STATE && reg_addr_i != C_EN && reg_addr_i != C_TEST;

  AST_TEST_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == C_TEST) |-> (reg_rdata_o == '0)); // R7

  AST_OTHER_WRITE_NO_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_other |=> $stable(en_q)); // R9

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    AST_EDGE_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (event_i[i] && !evt_q[i]) |=> state_q[i]); // R4
    AST_CLEAR_WORKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_state && reg_wdata_i[i] && !(event_i[i] && !evt_q[i])) |=> !state_q[i]); // R5
    AST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q[i] && !(wr_state && reg_wdata_i[i])) |=> state_q[i]); // R5
    AST_SET_BEATS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (event_i[i] && !evt_q[i] && wr_state && reg_wdata_i[i]) |=> state_q[i]); // R6
    AST_TEST_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_test && reg_wdata_i[i]) |=> state_q[i]); // R7
    AST_IRQ_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[i] |-> $past(en_q[i] && state_q[i])); // R8
  end
endmodule

bind irq_bank irq_bank_chk #(.NUM_SRC(NUM_SRC), .DW(DW), .AW(AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_addr_i(reg_addr_i), .reg_we_i(reg_we_i),
  .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .event_i(event_i),
  .irq_o(irq_o), .state_q(state_q), .en_q(en_q), .evt_q(evt_q)
);

// File: tb/tb_irq_bank.sv
module tb_irq_bank;
  localparam int N  = 8;
  localparam int DW = 32;
  localparam int AW = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n;
  logic [AW-1:0] addr;
  logic          we;
  logic [DW-1:0] wdata;
  logic [DW-1:0] rdata;
  logic [N-1:0]  evt;
  logic [N-1:0]  irq;

  irq_bank #(.NUM_SRC(N), .DW(DW), .AW(AW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_we_i(we),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .event_i(evt), .irq_o(irq)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  logic [N-1:0] m_state, m_en, m_irq, m_evq, m_set, m_clr;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = '0; m_en = '0; m_irq = '0; m_evq = '0;
    end else begin
      m_set = evt & ~m_evq;
      if (we && addr == 8'h08) m_set = m_set | wdata[N-1:0];
      m_clr = (we && addr == 8'h00) ? wdata[N-1:0] : '0;
      m_irq = m_state & m_en;
      m_state = (m_state & ~m_clr) | m_set;
      if (we && addr == 8'h04) m_en = wdata[N-1:0];
      m_evq = evt;
    end
  end

  function automatic logic [DW-1:0] exp_rd(input logic [AW-1:0] a);
    if (a == 8'h00) return DW'(m_state);
    if (a == 8'h04) return DW'(m_en);
    return '0;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R8 irq vs model", DW'(irq), DW'(m_irq));
      chk("R2 rdata vs model", rdata, exp_rd(addr));
    end
  end

  task automatic tick;
    @(negedge clk); #1;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    we = 1'b1; addr = a; wdata = d;
    tick();
    we = 1'b0; addr = 8'h00; wdata = '0;
  endtask

  task automatic rd_chk(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
    addr = a;
    @(negedge clk);
    chk(tag, rdata, exp);
    #1;
  endtask

  initial begin
    rst_n = 1'b0; addr = '0; we = 1'b0; wdata = '0; evt = '0;
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;

    rd_chk(8'h00, 32'h0, "R1 state after reset");
    rd_chk(8'h04, 32'h0, "R1 enable after reset");
    chk("R1 irq after reset", DW'(irq), 32'h0);

    wr(8'h04, 32'hFFFF_FFA5);
    rd_chk(8'h04, 32'h0000_00A5, "R2/R3 enable readback, upper bits zero");

    evt = 8'h01;
    tick();
    rd_chk(8'h00, 32'h01, "R4 edge sets bit 0");
    chk("R8 irq after state and enable", DW'(irq), 32'h01);

    wr(8'h00, 32'h1);
    rd_chk(8'h00, 32'h0, "R4 held-high input does not reset bit");

    evt = 8'h03;
    tick();
    evt = 8'h01;
    wr(8'h00, 32'hFFFF_FFFD);
    rd_chk(8'h00, 32'h02, "R5 zero write bits keep state");

    evt = 8'h05;
    wr(8'h00, 32'h4);
    rd_chk(8'h00, 32'h06, "R6 edge wins over clear");

    wr(8'h08, 32'h0000_0180);
    rd_chk(8'h08, 32'h0, "R7 test offset reads zero");
    rd_chk(8'h00, 32'h86, "R7 test write sets bit 7");
    wr(8'h00, 32'h80);
    rd_chk(8'h00, 32'h06, "R7 test value not kept");

    wr(8'h04, 32'h2);
    tick();
    chk("R8 irq masked by enable", DW'(irq), 32'h02);

    wr(8'h10, 32'hFFFF_FFFF);
    wr(8'h0C, 32'hFFFF_FFFF);
    rd_chk(8'h10, 32'h0, "R9 unmapped read zero");
    rd_chk(8'h04, 32'h02, "R9 enable untouched");
    rd_chk(8'h00, 32'h06, "R9 state untouched");

    begin
      logic [15:0] lfsr;
      lfsr = 16'hACE1;
      for (int k = 0; k < 400; k++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        if (lfsr[0]) evt = evt ^ (8'h1 << lfsr[3:1]);
        we    = lfsr[4] & lfsr[5];
        addr  = {4'h0, lfsr[7:6], 2'b00};
        wdata = {16'h0, lfsr[15:8], lfsr[7:0] ^ lfsr[15:8]};
        tick();
      end
      we = 1'b0; addr = 8'h00; wdata = '0;
      tick();
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule